// File: doc/BRIEF.md
# Page Write Commit Engine

This block sits behind a two-wire serial slave front end and in front of a small byte array. The front end hands it a starting word address and then a stream of received data bytes. Each byte lands in a page buffer at the offset given by the low bits of a shared address counter. Only those low bits advance, so a stream that runs past the end of a page wraps back to the first byte of the same page. Bytes sent past the page size overwrite bytes received earlier in the same sequence.

When the front end signals the stop that ends a write sequence, the engine runs a self-timed write cycle of a fixed, parameterised number of clock cycles. During this cycle it copies every buffered byte into the array through a one-byte write port and holds busy high. While busy is high, every input from the front end is ignored. A write-protect input guards the upper half of the array. Protected bytes are dropped without notice, but the timed cycle still runs to its full length.

The page size is 8 bytes (256-byte array) or 16 bytes (512-byte array), always in 32 pages.

Top module: `page_commit_engine`

## Requirements
- R1: `PAGE_BYTES` of 8 gives an 8-bit address over 256 bytes, and 16 gives a 9-bit address over 512 bytes, both in `NUM_PAGES` = 32 pages. The page row is the address bits above the in-page offset, and the last page wraps within itself like any other.
- R2: After reset, `busy_o` and `mem_we_o` are low, `cur_addr_o` is 0 and no bytes are buffered.
- R3: With `busy_o` low, a pulse on `addr_load_i` places `addr_i` in `cur_addr_o` on the next clock and discards every byte buffered so far. A load in the same cycle as `byte_valid_i` wins, and that byte is dropped.
- R4: With `busy_o` low, a byte on `byte_valid_i` is buffered at offset `cur_addr_o[OFS_W-1:0]`. Then only those low bits of `cur_addr_o` increment, wrapping from the last offset of the page to offset 0 while the page row stays unchanged.
- R5: When more than `PAGE_BYTES` bytes arrive in one sequence, a later byte replaces the earlier byte buffered at the same offset, and only the latest value is committed.
- R6: Only offsets that received a byte are written. Every other array location keeps its value.
- R7: A `stop_i` pulse while idle with at least one byte buffered raises `busy_o` on the next clock, holds it for exactly `WR_CYCLES` cycles, and then lowers it. A stop with nothing buffered starts no cycle.
- R8: While `busy_o` is high, `addr_load_i`, `byte_valid_i` and `stop_i` have no effect. `cur_addr_o` stays unchanged, no byte is buffered and no further cycle is started.
- R9: A buffered byte whose address MSB is 1 is not written if `wp_i` is high in the cycle it would be written. Lower-half bytes are always written, and the cycle length does not depend on `wp_i`.
- R10: After a commit, `cur_addr_o` holds the last received address plus one, wrapped within the page. The buffer is empty, so a following stop starts no cycle.
- R11: `mem_we_o` is high only while `busy_o` is high, for at most one write per buffered offset, in the first `PAGE_BYTES` cycles of the write cycle, at `{page row, offset}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Write protect for the upper half of the array |
| addr_load_i | input | 1 | Load the start word address |
| addr_i | input | AW | Start word address |
| byte_valid_i | input | 1 | One received data byte is present |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | Stop ending the sequence; starts the commit |
| busy_o | output | 1 | Self-timed write cycle in progress |
| cur_addr_o | output | AW | Shared word address counter |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | AW | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The bench goes after the following corner cases, each with the failure it would show:
- **Page-end wrap.** A counter that carries into the page row would spill bytes into the next page and leave the wrong address after the sequence.
- **Overflow past the page size.** A buffer that ignores repeated offsets would commit stale first-pass data.
- **Partial pages.** A design without a per-byte mask would corrupt the untouched neighbours.
- **Inputs during the timed cycle.** A design that listens while busy would move the address counter, buffer a byte, or chain a second cycle. An uncleared mask would let a bare stop restart the cycle.
- **Write protect.** The bench checks both that protected upper-half bytes are dropped and that the busy time is unchanged, so a design that skips the cycle for protected data is caught.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic {
    PH_FILL   = 1'b0,
    PH_COMMIT = 1'b1
  } phase_e;
endpackage

// File: rtl/pwc_addr_ctr.sv
module pwc_addr_ctr #(
  parameter int unsigned AW    = 8,
  parameter int unsigned OFS_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= load_val_i;
    end else if (step_i) begin
      // only the in-page offset advances
      addr_q <= {addr_q[AW-1:OFS_W], addr_q[OFS_W-1:0] + 1'b1};
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int unsigned PAGE_BYTES = 8,
  parameter int unsigned OFS_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [OFS_W-1:0] wr_ofs_i,
  input  logic [7:0]       wr_data_i,
  input  logic             clr_i,
  input  logic [OFS_W-1:0] rd_ofs_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_vld_o,
  output logic             any_vld_o
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_ofs_i == OFS_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[i] <= '0;
        vld_q[i]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[i]  <= 1'b0;
      end else if (hit) begin
        data_q[i] <= wr_data_i;
        vld_q[i]  <= 1'b1;
      end
    end
  end

  assign rd_data_o = data_q[rd_ofs_i];
  assign rd_vld_o  = vld_q[rd_ofs_i];
  assign any_vld_o = |vld_q;
endmodule

// File: rtl/pwc_commit_timer.sv
module pwc_commit_timer
  import pwc_pkg::*;
#(
  parameter int unsigned WR_CYCLES  = 64,  // must be >= PAGE_BYTES
  parameter int unsigned PAGE_BYTES = 8,
  parameter int unsigned OFS_W      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             in_page_o,
  output logic             done_o,
  output logic [OFS_W-1:0] idx_o
);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES) + 1;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q == CNT_W'(WR_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FILL;
      cnt_q   <= '0;
    end else if (phase_q == PH_FILL) begin
      if (start_i) begin
        phase_q <= PH_COMMIT;
        cnt_q   <= '0;
      end
    end else if (last) begin
      phase_q <= PH_FILL;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o    = (phase_q == PH_COMMIT);
  assign done_o    = busy_o && last;
  assign in_page_o = busy_o && (cnt_q < CNT_W'(PAGE_BYTES));
  assign idx_o     = cnt_q[OFS_W-1:0];
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine #(
  parameter int unsigned PAGE_BYTES = 8,
  parameter int unsigned NUM_PAGES  = 32,
  parameter int unsigned WR_CYCLES  = 64,
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES),
  localparam int unsigned AW        = $clog2(PAGE_BYTES * NUM_PAGES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wp_i,
  input  logic          addr_load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_i,
  input  logic          stop_i,
  output logic          busy_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o
);
  logic             busy, in_page, done;
  logic [OFS_W-1:0] idx;
  logic [AW-1:0]    addr;
  logic             load_en, byte_en, start, clr;
  logic [7:0]       rd_data;
  logic             rd_vld, any_vld, protect;

  // stop has priority, then load, then data
  assign load_en = !busy && !stop_i && addr_load_i;
  assign byte_en = !busy && !stop_i && !addr_load_i && byte_valid_i;
  assign start   = !busy && stop_i && any_vld;
  assign clr     = load_en || done;

  pwc_addr_ctr #(.AW(AW), .OFS_W(OFS_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_en),
    .load_val_i (addr_i),
    .step_i     (byte_en),
    .addr_o     (addr)
  );

  pwc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (byte_en),
    .wr_ofs_i  (addr[OFS_W-1:0]),
    .wr_data_i (byte_i),
    .clr_i     (clr),
    .rd_ofs_i  (idx),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld),
    .any_vld_o (any_vld)
  );

  pwc_commit_timer #(
    .WR_CYCLES (WR_CYCLES),
    .PAGE_BYTES(PAGE_BYTES),
    .OFS_W     (OFS_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .busy_o    (busy),
    .in_page_o (in_page),
    .done_o    (done),
    .idx_o     (idx)
  );

  // write protect sampled per byte at commit time
  assign protect     = wp_i && addr[AW-1];
  assign mem_we_o    = in_page && rd_vld && !protect;
  assign mem_addr_o  = {addr[AW-1:OFS_W], idx};
  assign mem_wdata_o = rd_data;
  assign busy_o      = busy;
  assign cur_addr_o  = addr;
endmodule

// File: rtl/page_commit_engine_chk.sv
module page_commit_engine_chk #(
  parameter int unsigned AW        = 8,
  parameter int unsigned WR_CYCLES = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wp_i,
  input logic          stop_i,
  input logic          busy_o,
  input logic [AW-1:0] cur_addr_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  AST_WE_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);  // R11
  AST_WP_UPPER_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && wp_i) |-> !mem_addr_o[AW-1]);  // R9
  AST_BUSY_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));  // R7
  AST_BUSY_NOT_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < WR_CYCLES));  // R7
  AST_BUSY_EXACT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == WR_CYCLES));  // R7
  AST_ADDR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cur_addr_o));  // R8
endmodule

bind page_commit_engine page_commit_engine_chk #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wp_i       (wp_i),
  .stop_i     (stop_i),
  .busy_o     (busy_o),
  .cur_addr_o (cur_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/page_commit_engine_test.sv
module page_commit_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int PB  = 8;
  localparam int WR  = 24;
  localparam int AW  = 8;
  localparam int MSZ = 256;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wp_i = 1'b0, addr_load_i = 1'b0, byte_valid_i = 1'b0, stop_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    byte_i = '0;
  logic          busy_o, mem_we_o;
  logic [AW-1:0] cur_addr_o, mem_addr_o;
  logic [7:0]    mem_wdata_o;

  int checks = 0, fails = 0, we_cnt = 0;
  logic [7:0] arr [MSZ];
  logic [7:0] exp_arr [MSZ];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  page_commit_engine #(.PAGE_BYTES(PB), .NUM_PAGES(32), .WR_CYCLES(WR)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wp_i(wp_i), .addr_load_i(addr_load_i),
    .addr_i(addr_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i), .stop_i(stop_i),
    .busy_o(busy_o), .cur_addr_o(cur_addr_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  // array model
  always @(posedge clk_i) begin
    if (rst_ni && mem_we_o) begin
      arr[mem_addr_o] <= mem_wdata_o;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_arr(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < MSZ; i++)
      if (arr[i] !== exp_arr[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, req, (first < 0) ? 0 : arr[first], (first < 0) ? 0 : exp_arr[first]);
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    @(negedge clk_i); addr_load_i = 1'b1; addr_i = a;
    @(negedge clk_i); addr_load_i = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] b);
    @(negedge clk_i); byte_valid_i = 1'b1; byte_i = b;
    @(negedge clk_i); byte_valid_i = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk_i); stop_i = 1'b1;
    @(negedge clk_i); stop_i = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset();
    chk(busy_o == 1'b0, "R2 busy", busy_o, 0);
    chk(cur_addr_o == '0, "R2 addr", cur_addr_o, 0);
    chk(mem_we_o == 1'b0, "R2 we", mem_we_o, 0);
    do_stop();
    chk(busy_o == 1'b0, "R2 empty buffer", busy_o, 0);
  endtask

  task automatic t_partial();
    int n, w0;
    do_load(8'h13);
    chk(cur_addr_o == 8'h13, "R3 load", cur_addr_o, 8'h13);
    do_byte(8'hA1); do_byte(8'hB2); do_byte(8'hC3);
    chk(cur_addr_o == 8'h16, "R4 increment", cur_addr_o, 8'h16);
    w0 = we_cnt;
    do_stop();
    chk(busy_o == 1'b1, "R7 busy rises", busy_o, 1);
    wait_idle(n);
    chk(n == WR, "R7 cycle length", n, WR);
    chk(we_cnt - w0 == 3, "R11 write count", we_cnt - w0, 3);
    exp_arr[8'h13] = 8'hA1; exp_arr[8'h14] = 8'hB2; exp_arr[8'h15] = 8'hC3;
    chk_arr("R6 partial page");
    chk(cur_addr_o == 8'h16, "R10 addr after commit", cur_addr_o, 8'h16);
  endtask

  task automatic t_wrap();
    int n;
    do_load(8'h2E);
    do_byte(8'h01); do_byte(8'h02); do_byte(8'h03); do_byte(8'h04);
    chk(cur_addr_o == 8'h2A, "R4 in-page wrap", cur_addr_o, 8'h2A);
    do_stop(); wait_idle(n);
    exp_arr[8'h2E] = 8'h01; exp_arr[8'h2F] = 8'h02;
    exp_arr[8'h28] = 8'h03; exp_arr[8'h29] = 8'h04;
    chk_arr("R4 wrap data");
  endtask

  task automatic t_last_page();
    int n;
    do_load(8'hFB);
    for (int k = 0; k < 6; k++) do_byte(8'h70 + 8'(k));
    chk(cur_addr_o == 8'hF9, "R1 last page wrap", cur_addr_o, 8'hF9);
    do_stop(); wait_idle(n);
    for (int k = 0; k < 5; k++) exp_arr[8'hFB + k] = 8'h70 + 8'(k);
    exp_arr[8'hF8] = 8'h75;
    chk_arr("R1 last page data");
  endtask

  task automatic t_overflow();
    int n, w0;
    do_load(8'h40);
    for (int k = 0; k < 10; k++) do_byte(8'hC0 + 8'(k));
    chk(cur_addr_o == 8'h42, "R5 addr", cur_addr_o, 8'h42);
    w0 = we_cnt;
    do_stop(); wait_idle(n);
    chk(we_cnt - w0 == PB, "R11 one write per offset", we_cnt - w0, PB);
    for (int k = 2; k < 10; k++) exp_arr[8'h40 + (k % 8)] = 8'hC0 + 8'(k);
    chk_arr("R5 overwrite");
  endtask

  task automatic t_busy_ignore();
    int n;
    do_load(8'h30); do_byte(8'h11);
    do_stop();
    do_load(8'h70); do_byte(8'h99); do_stop();
    chk(busy_o == 1'b1, "R8 still busy", busy_o, 1);
    wait_idle(n);
    exp_arr[8'h30] = 8'h11;
    chk(cur_addr_o == 8'h31, "R8 addr untouched", cur_addr_o, 8'h31);
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0, "R8 stop ignored", busy_o, 0);
    chk_arr("R8 no write at 0x70");
    do_stop();
    chk(busy_o == 1'b0, "R10 buffer cleared", busy_o, 0);
  endtask

  task automatic t_reload();
    int n;
    do_load(8'h50); do_byte(8'h5E);
    do_load(8'h60);
    chk(cur_addr_o == 8'h60, "R3 reload", cur_addr_o, 8'h60);
    do_byte(8'h6E);
    do_stop(); wait_idle(n);
    exp_arr[8'h60] = 8'h6E;
    chk_arr("R3 discard on load");
    // load wins over a simultaneous byte
    @(negedge clk_i); addr_load_i = 1'b1; addr_i = 8'h68; byte_valid_i = 1'b1; byte_i = 8'hEE;
    @(negedge clk_i); addr_load_i = 1'b0; byte_valid_i = 1'b0;
    chk(cur_addr_o == 8'h68, "R3 load priority", cur_addr_o, 8'h68);
    do_stop();
    chk(busy_o == 1'b0, "R3 byte dropped", busy_o, 0);
  endtask

  task automatic t_protect();
    int n, w0;
    @(negedge clk_i); wp_i = 1'b1;
    do_load(8'h90); do_byte(8'hD1); do_byte(8'hD2);
    w0 = we_cnt;
    do_stop(); wait_idle(n);
    chk(n == WR, "R9 cycle length kept", n, WR);
    chk(we_cnt == w0, "R9 upper blocked", we_cnt - w0, 0);
    chk(cur_addr_o == 8'h92, "R10 addr after protected", cur_addr_o, 8'h92);
    do_load(8'h20); do_byte(8'hD3);
    do_stop(); wait_idle(n);
    exp_arr[8'h20] = 8'hD3;
    chk_arr("R9 lower half writable");
    @(negedge clk_i); wp_i = 1'b0;
    do_load(8'h90); do_byte(8'hD4);
    do_stop(); wait_idle(n);
    exp_arr[8'h90] = 8'hD4;
    chk_arr("R9 upper writable when clear");
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) begin
      arr[i] = 8'(i) ^ 8'h5A;
      exp_arr[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_partial();
    t_wrap();
    t_last_page();
    t_overflow();
    t_busy_ignore();
    t_reload();
    t_protect();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule